// File: doc/BRIEF.md
# Flag Decoder and Block Framer for a Single-Wire Command Link

This block sits between a byte-level receiver/transmitter and a command engine on a half-duplex single-wire link. Every exchange opens with one flag byte from the host. The block decodes that flag and acts on it. A command flag opens a framed block, which the block checks and whose packet bytes it passes to the command engine. A transmit flag makes the block send the currently held response as a framed block. A sleep flag raises a one-cycle sleep request. Any other flag value is dropped.

A framed block starts with a length byte. That byte counts the whole block, including itself and the two check bytes. The packet bytes follow, and the block ends with a CRC-16 sent low byte first. Packet bytes are streamed to the command engine as they arrive. The verdict comes when the last byte lands: either an accept pulse or an abort pulse. A rejected block replaces the held response with a communications-error code.

The command engine fills the response store with result bytes and then closes the command. It can instead report an execution error. The host may read the held response as often as it likes. Bit timing and command execution belong to neighbouring blocks.

Top module: `fb_link_framer`

## Requirements
- R1: In the flag position, byte 0x66 opens a block, 0x99 requests transmission and 0xCC pulses `sleep_o` one cycle later. Every other value has no effect: no output moves and the held response is unchanged.
- R2: The first byte of a block is its total length N, counting itself and both CRC bytes. When N is between 4 and 39, bytes 1 to N-3 appear in order on `cmd_data_o` with `cmd_valid_o`, and `cmd_first_o` marks byte 1.
- R3: The CRC-16 uses polynomial 0x8005 and starts at 0. It runs over the length byte and the packet bytes, one bit at a time, least significant bit of each byte first. The CRC low byte comes at position N-2 and the high byte at N-1. When the received CRC matches, `cmd_end_o` pulses once and the block enters the busy state.
- R4: A block with a legal length but a CRC mismatch pulses `cmd_abort_o`, and the held response becomes the single byte 0xFF.
- R5: A length outside 4..39 forwards no packet bytes. Such a block ends after max(N,1) bytes, during which flag codes are not decoded. It then pulses `cmd_abort_o`, and the held response becomes 0xFF.
- R6: After reset or a sleep flag, all outputs are idle, no command is busy and the held response is the single byte 0x11.
- R7: On a transmit flag, the block sends: length (packet length + 3), the packet, then the CRC low and high bytes computed as in R3. Bytes advance only when `tx_ready_i` is high; while it is low, `tx_valid_o` and `tx_data_o` hold.
- R8: While a command is busy (accepted and not yet closed), transmit and command flags are ignored, but a sleep flag still acts.
- R9: While busy, `exec_err_i` makes the response 0x0F. Bytes pushed with `rsp_push_i` followed by `rsp_done_i` form the response. A close with no bytes yields 0x00. Pushes beyond 8 bytes (default depth) are dropped.
- R10: Repeated transmit flags return the same block every time.
- R11: Bytes received while a response is being sent are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| cmd_valid_o | output | 1 | Packet byte valid toward command engine |
| cmd_first_o | output | 1 | Marks the first packet byte |
| cmd_data_o | output | 8 | Packet byte |
| cmd_end_o | output | 1 | Block accepted (CRC good) |
| cmd_abort_o | output | 1 | Block rejected (length or CRC) |
| rsp_push_i | input | 1 | Append a response byte |
| rsp_data_i | input | 8 | Response byte |
| rsp_done_i | input | 1 | Command finished, response complete |
| exec_err_i | input | 1 | Command failed in execution |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_data_o | output | 8 | Outgoing byte |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| sleep_o | output | 1 | One-cycle sleep request |

## Verification
The bench targets the length limits at 4 and 39, a length of 0 that ends the block on its first byte, and lengths of 3 and 40 that must swallow flag codes without acting on them. A design with an off-by-one in the length would either forward a CRC byte as packet or treat the next flag as block data. Flipped CRC bit order or swapped CRC bytes show up as wrong accept/abort verdicts and as a mismatch in the transmitted trailer. Two cases check that flags during a busy command or an active transmission are dropped: a leak there would produce replies from the wrong state or a spurious sleep pulse. Another looks at response overflow and empty closes, where a wrong store would send garbage or an empty block.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam logic [7:0] FLAG_CMD    = 8'h66;
  localparam logic [7:0] FLAG_TX     = 8'h99;
  localparam logic [7:0] FLAG_SLEEP  = 8'hCC;
  localparam logic [7:0] ST_WAKE     = 8'h11;
  localparam logic [7:0] ST_COMM_ERR = 8'hFF;
  localparam logic [7:0] ST_EXEC_ERR = 8'h0F;
  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [15:0] CRC_POLY   = 16'h8005;

  typedef enum logic {RX_FLAG, RX_BLOCK} rx_state_e;
endpackage

// File: rtl/fb_crc_step.sv
module fb_crc_step #(
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic [15:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] acc;
  logic        fb;

  // wire order: bit 0 of each byte first
  always_comb begin
    acc = crc_i;
    fb  = 1'b0;
    for (int i = 0; i < 8; i++) begin
      fb  = data_i[i] ^ acc[15];
      acc = {acc[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    end
    crc_o = acc;
  end
endmodule

// File: rtl/fb_rx_framer.sv
module fb_rx_framer
  import fb_pkg::*;
#(
  parameter int MIN_COUNT = 4,
  parameter int MAX_COUNT = 39
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       busy_i,
  input  logic       tx_busy_i,
  output logic       cmd_valid_o,
  output logic       cmd_first_o,
  output logic [7:0] cmd_data_o,
  output logic       ev_ok_o,
  output logic       ev_err_o,
  output logic       ev_tx_o,
  output logic       ev_sleep_o
);
  localparam logic [7:0] MIN_C = 8'(MIN_COUNT);
  localparam logic [7:0] MAX_C = 8'(MAX_COUNT);

  rx_state_e   state_q;
  logic [7:0]  idx_q, len_q, crc_lo_q;
  logic        bad_q;
  logic [15:0] crc_q, crc_in, crc_nxt;

  logic       take, in_flag, open_blk, in_blk, first_b, bad_now, last_b;
  logic       pkt_b, lo_b, crc_match;
  logic [7:0] len_now;

  assign take     = rx_valid_i && !tx_busy_i;
  assign in_flag  = take && (state_q == RX_FLAG);
  assign in_blk   = take && (state_q == RX_BLOCK);
  assign first_b  = in_blk && (idx_q == 8'd0);

  assign open_blk   = in_flag && (rx_data_i == FLAG_CMD) && !busy_i;
  assign ev_tx_o    = in_flag && (rx_data_i == FLAG_TX) && !busy_i;
  assign ev_sleep_o = in_flag && (rx_data_i == FLAG_SLEEP);

  assign len_now = first_b ? ((rx_data_i == 8'd0) ? 8'd1 : rx_data_i) : len_q;
  assign bad_now = first_b ? ((rx_data_i < MIN_C) || (rx_data_i > MAX_C)) : bad_q;
  assign last_b  = in_blk && (idx_q == len_now - 8'd1);
  assign pkt_b   = in_blk && !first_b && !bad_now && (idx_q <= len_now - 8'd3);
  assign lo_b    = in_blk && !first_b && (idx_q == len_now - 8'd2);

  assign crc_in    = first_b ? 16'h0000 : crc_q;
  assign crc_match = ({rx_data_i, crc_lo_q} == crc_q);

  assign ev_ok_o  = last_b && !bad_now && crc_match;
  assign ev_err_o = last_b && (bad_now || !crc_match);

  fb_crc_step #(.POLY(CRC_POLY)) u_crc (
    .crc_i (crc_in),
    .data_i(rx_data_i),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_FLAG;
      idx_q    <= '0;
      len_q    <= '0;
      bad_q    <= 1'b0;
      crc_q    <= '0;
      crc_lo_q <= '0;
    end else begin
      if (open_blk) begin
        state_q <= RX_BLOCK;
        idx_q   <= '0;
      end
      if (in_blk) begin
        idx_q <= idx_q + 8'd1;
        if (first_b) begin
          len_q <= len_now;
          bad_q <= bad_now;
          crc_q <= crc_nxt;
        end else if (pkt_b) begin
          crc_q <= crc_nxt;
        end
        if (lo_b) crc_lo_q <= rx_data_i;
        if (last_b) state_q <= RX_FLAG;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_first_o <= 1'b0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= pkt_b;
      cmd_first_o <= pkt_b && (idx_q == 8'd1);
      if (pkt_b) cmd_data_o <= rx_data_i;
    end
  end
endmodule

// File: rtl/fb_rsp_store.sv
module fb_rsp_store
  import fb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_i,
  input  logic          ld_err_i,
  input  logic          start_i,
  input  logic          push_i,
  input  logic [7:0]    data_i,
  input  logic          done_i,
  input  logic          exec_err_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [LW-1:0] len_o,
  output logic          busy_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] len_q, len_d;
  logic          busy_q, busy_d;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;
  logic [7:0]    rows [DEPTH];

  always_comb begin
    len_d   = len_q;
    busy_d  = busy_q;
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = '0;
    if (sleep_i) begin
      wr_en = 1'b1; wr_data = ST_WAKE; len_d = LW'(1); busy_d = 1'b0;
    end else if (ld_err_i) begin
      wr_en = 1'b1; wr_data = ST_COMM_ERR; len_d = LW'(1); busy_d = 1'b0;
    end else if (start_i) begin
      len_d = '0; busy_d = 1'b1;
    end else if (busy_q) begin
      if (exec_err_i) begin
        wr_en = 1'b1; wr_data = ST_EXEC_ERR; len_d = LW'(1); busy_d = 1'b0;
      end else begin
        if (push_i && (len_q < FULL)) begin
          wr_en   = 1'b1;
          wr_idx  = IW'(len_q);
          wr_data = data_i;
          len_d   = len_q + LW'(1);
        end
        if (done_i) begin
          busy_d = 1'b0;
          if (!push_i && (len_q == '0)) begin
            wr_en = 1'b1; wr_data = ST_OK; len_d = LW'(1);
          end
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= (g == 0) ? ST_WAKE : 8'h00;
      else if (wr_en && (wr_idx == IW'(g)))   q <= wr_data;
    end
    assign rows[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= LW'(1);
      busy_q <= 1'b0;
    end else begin
      len_q  <= len_d;
      busy_q <= busy_d;
    end
  end

  assign rd_data_o = rows[rd_idx_i];
  assign len_o     = len_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/fb_tx_framer.sv
module fb_tx_framer
  import fb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 3)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic [IW-1:0] rd_idx_o,
  input  logic [7:0]    rd_data_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  output logic          busy_o
);
  logic          active_q;
  logic [PW-1:0] pos_q, lenp;
  logic [15:0]   crc_q, crc_in, crc_nxt;
  logic          fire, last_b, body_b;

  assign lenp     = PW'(len_i);
  assign rd_idx_o = IW'(pos_q - PW'(1));
  assign body_b   = (pos_q <= lenp);
  assign last_b   = (pos_q == lenp + PW'(2));
  assign fire     = active_q && tx_ready_i;

  always_comb begin
    if (pos_q == '0)                 tx_data_o = 8'(len_i) + 8'd3;
    else if (body_b)                 tx_data_o = rd_data_i;
    else if (pos_q == lenp + PW'(1)) tx_data_o = crc_q[7:0];
    else                             tx_data_o = crc_q[15:8];
  end

  assign crc_in = (pos_q == '0) ? 16'h0000 : crc_q;

  fb_crc_step #(.POLY(CRC_POLY)) u_crc (
    .crc_i (crc_in),
    .data_i(tx_data_o),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      crc_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      pos_q    <= '0;
    end else if (fire) begin
      pos_q <= pos_q + PW'(1);
      if (body_b) crc_q <= crc_nxt;
      if (last_b) active_q <= 1'b0;
    end
  end

  assign tx_valid_o = active_q;
  assign busy_o     = active_q;
endmodule

// File: rtl/fb_link_framer.sv
module fb_link_framer #(
  parameter int RSP_DEPTH = 8,
  parameter int MIN_COUNT = 4,
  parameter int MAX_COUNT = 39
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       cmd_valid_o,
  output logic       cmd_first_o,
  output logic [7:0] cmd_data_o,
  output logic       cmd_end_o,
  output logic       cmd_abort_o,
  input  logic       rsp_push_i,
  input  logic [7:0] rsp_data_i,
  input  logic       rsp_done_i,
  input  logic       exec_err_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i,
  output logic       sleep_o
);
  localparam int LW = $clog2(RSP_DEPTH + 1);
  localparam int IW = $clog2(RSP_DEPTH);

  logic          ev_ok, ev_err, ev_tx, ev_sleep;
  logic          rsp_busy, tx_busy;
  logic [LW-1:0] rsp_len;
  logic [IW-1:0] rd_idx;
  logic [7:0]    rd_data;

  fb_rx_framer #(.MIN_COUNT(MIN_COUNT), .MAX_COUNT(MAX_COUNT)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .busy_i     (rsp_busy),
    .tx_busy_i  (tx_busy),
    .cmd_valid_o(cmd_valid_o),
    .cmd_first_o(cmd_first_o),
    .cmd_data_o (cmd_data_o),
    .ev_ok_o    (ev_ok),
    .ev_err_o   (ev_err),
    .ev_tx_o    (ev_tx),
    .ev_sleep_o (ev_sleep)
  );

  fb_rsp_store #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (ev_sleep),
    .ld_err_i  (ev_err),
    .start_i   (ev_ok),
    .push_i    (rsp_push_i),
    .data_i    (rsp_data_i),
    .done_i    (rsp_done_i),
    .exec_err_i(exec_err_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .len_o     (rsp_len),
    .busy_o    (rsp_busy)
  );

  fb_tx_framer #(.DEPTH(RSP_DEPTH)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (ev_tx),
    .len_i     (rsp_len),
    .rd_idx_o  (rd_idx),
    .rd_data_i (rd_data),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .tx_ready_i(tx_ready_i),
    .busy_o    (tx_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_end_o   <= 1'b0;
      cmd_abort_o <= 1'b0;
      sleep_o     <= 1'b0;
    end else begin
      cmd_end_o   <= ev_ok;
      cmd_abort_o <= ev_err;
      sleep_o     <= ev_sleep;
    end
  end
endmodule

// File: rtl/fb_link_framer_chk.sv
module fb_link_framer_chk #(
  parameter int RSP_DEPTH = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       cmd_valid_o,
  input logic       cmd_first_o,
  input logic       cmd_end_o,
  input logic       cmd_abort_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i,
  input logic       sleep_o
);
  p_tx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_count_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> (tx_data_o >= 8'd4 && tx_data_o <= 8'(RSP_DEPTH + 3)));

  p_one_outcome_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_end_o, cmd_abort_o, sleep_o}));

  p_end_needs_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_end_o || cmd_abort_o) |-> $past(rx_valid_i));

  p_sleep_from_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> $past(rx_valid_i && rx_data_i == 8'hCC));

  p_first_is_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_first_o |-> cmd_valid_o);

  p_no_cmd_in_tx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !tx_valid_o);
endmodule

bind fb_link_framer fb_link_framer_chk #(.RSP_DEPTH(RSP_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_data_i  (rx_data_i),
  .cmd_valid_o(cmd_valid_o),
  .cmd_first_o(cmd_first_o),
  .cmd_end_o  (cmd_end_o),
  .cmd_abort_o(cmd_abort_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .sleep_o    (sleep_o)
);

// File: tb/sim_fb_link_framer.sv
module sim_fb_link_framer;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic cmd_valid_o, cmd_first_o, cmd_end_o, cmd_abort_o;
  logic [7:0] cmd_data_o;
  logic rsp_push_i = 1'b0;
  logic [7:0] rsp_data_i = '0;
  logic rsp_done_i = 1'b0;
  logic exec_err_i = 1'b0;
  logic tx_valid_o;
  logic [7:0] tx_data_o;
  logic tx_ready_i = 1'b1;
  logic sleep_o;

  always #4 clk_i = ~clk_i;

  fb_link_framer u0 (.*);

  int n_checks = 0, n_errors = 0;
  int n_end = 0, n_abort = 0, n_sleep = 0;
  int cyc = 0, ready_mode = 2;
  logic [7:0] exp_cmd[$];
  logic       exp_first[$];
  logic [7:0] txq[$];
  logic [7:0] blk[$];
  logic       hold_prev = 1'b0;
  logic [7:0] hold_data = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ready pattern
  always @(posedge clk_i) begin
    cyc++;
    #1;
    case (ready_mode)
      0: tx_ready_i = (cyc % 3) != 0;
      1: tx_ready_i = 1'b0;
      default: tx_ready_i = 1'b1;
    endcase
  end

  // reference comparison each clock
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (cmd_valid_o) begin
        if (exp_cmd.size() == 0) chk("R2 unexpected packet byte", cmd_data_o, -1);
        else begin
          chk("R2 packet byte", cmd_data_o, exp_cmd.pop_front());
          chk("R2 first marker", cmd_first_o, exp_first.pop_front());
        end
      end
      if (cmd_end_o) n_end++;
      if (cmd_abort_o) n_abort++;
      if (sleep_o) n_sleep++;
      if (hold_prev) begin
        chk("R7 valid held", tx_valid_o, 1);
        chk("R7 data held", tx_data_o, hold_data);
      end
      if (tx_valid_o && tx_ready_i) txq.push_back(tx_data_o);
      hold_prev = tx_valid_o && !tx_ready_i;
      hold_data = tx_data_o;
    end
  end

  function automatic logic [15:0] crc16(input logic [7:0] q[$]);
    int r = 0;
    foreach (q[k]) begin
      for (int b = 0; b < 8; b++) begin
        int top = (r >> 15) & 1;
        int bit_v = (q[k] >> b) & 1;
        r = (r << 1) & 16'hFFFF;
        if ((top ^ bit_v) == 1) r = r ^ 16'h8005;
      end
    end
    return 16'(r);
  endfunction

  task automatic make_block(input logic [7:0] pkt[$]);
    logic [15:0] c;
    blk = {};
    blk.push_back(8'(pkt.size() + 3));
    foreach (pkt[k]) blk.push_back(pkt[k]);
    c = crc16(blk);
    blk.push_back(c[7:0]);
    blk.push_back(c[15:8]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk_i); #1;
    rx_valid_i = 1'b1;
    rx_data_i  = b;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk_i); #1;
      rx_valid_i = 1'b0;
    end
  endtask

  task automatic send_cmd(input logic [7:0] pkt[$], input bit good);
    make_block(pkt);
    if (!good) blk[blk.size()-1] = blk[blk.size()-1] ^ 8'h04;
    foreach (pkt[k]) begin
      exp_cmd.push_back(pkt[k]);
      exp_first.push_back(k == 0);
    end
    send_byte(8'h66);
    foreach (blk[k]) send_byte(blk[k]);
    idle(4);
  endtask

  task automatic read_expect(input string tag, input logic [7:0] pkt[$]);
    logic [7:0] want[$];
    int t = 0;
    make_block(pkt);
    want = blk;
    txq.delete();
    send_byte(8'h99);
    idle(1);
    while (txq.size() < want.size() && t < 400) begin idle(1); t++; end
    idle(3);
    chk({tag, " length"}, txq.size(), want.size());
    foreach (want[k]) if (k < txq.size()) chk({tag, " byte"}, txq[k], want[k]);
  endtask

  task automatic expect_silent(input string tag);
    txq.delete();
    send_byte(8'h99);
    idle(30);
    chk(tag, txq.size(), 0);
  endtask

  task automatic push_rsp(input logic [7:0] bytes_in[$]);
    foreach (bytes_in[k]) begin
      @(posedge clk_i); #1;
      rsp_push_i = 1'b1; rsp_data_i = bytes_in[k];
    end
    @(posedge clk_i); #1;
    rsp_push_i = 1'b0; rsp_done_i = 1'b1;
    @(posedge clk_i); #1;
    rsp_done_i = 1'b0;
    idle(2);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] p[$];
    int e0, a0, s0;
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R6 reset state
    chk("R6 tx idle", tx_valid_o, 0);
    chk("R6 cmd idle", cmd_valid_o, 0);
    chk("R6 sleep idle", sleep_o, 0);
    read_expect("R6 wake code", '{8'h11});
    read_expect("R10 reread", '{8'h11});

    // R1 unknown flags ignored
    e0 = n_end; a0 = n_abort; s0 = n_sleep;
    txq.delete();
    send_byte(8'h12); send_byte(8'h00); send_byte(8'hFF); send_byte(8'h67);
    idle(10);
    chk("R1 no tx on unknown flag", txq.size(), 0);
    chk("R1 no outcome on unknown flag", n_end + n_abort + n_sleep - e0 - a0 - s0, 0);
    read_expect("R1 response unchanged", '{8'h11});

    // R2/R3 good block, then busy behaviour R8
    ready_mode = 0;
    e0 = n_end;
    send_cmd('{8'h08, 8'h01, 8'h00, 8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF}, 1);
    chk("R3 accept pulse", n_end - e0, 1);
    chk("R2 all packet bytes seen", exp_cmd.size(), 0);
    expect_silent("R8 transmit ignored while busy");
    e0 = n_end; a0 = n_abort;
    send_byte(8'h66); send_byte(8'h05); send_byte(8'h01); send_byte(8'h02);
    idle(6);
    chk("R8 command flag ignored while busy", n_end + n_abort - e0 - a0, 0);
    push_rsp('{8'hAA, 8'h55, 8'h3C});
    read_expect("R9 pushed response R7", '{8'hAA, 8'h55, 8'h3C});
    read_expect("R10 reread pushed", '{8'hAA, 8'h55, 8'h3C});

    // R4 CRC mismatch
    a0 = n_abort; e0 = n_end;
    send_cmd('{8'h40, 8'h20, 8'h00, 8'h00, 8'h11}, 0);
    chk("R4 abort pulse", n_abort - a0, 1);
    chk("R4 no accept", n_end - e0, 0);
    read_expect("R4 comm error code", '{8'hFF});

    // R5 length 3 swallows flag codes
    a0 = n_abort; s0 = n_sleep;
    send_byte(8'h66); send_byte(8'h03); send_byte(8'h99); send_byte(8'hCC);
    idle(4);
    chk("R5 length 3 abort", n_abort - a0, 1);
    chk("R5 no sleep inside block", n_sleep - s0, 0);
    // R5 length 40
    a0 = n_abort;
    send_byte(8'h66); send_byte(8'd40);
    for (int k = 0; k < 39; k++) send_byte(8'h66);
    idle(4);
    chk("R5 length 40 abort", n_abort - a0, 1);
    read_expect("R5 comm error after 40", '{8'hFF});

    // R9 execution error
    send_cmd('{8'h08, 8'h00, 8'h00, 8'h00}, 1);
    @(posedge clk_i); #1 exec_err_i = 1'b1;
    @(posedge clk_i); #1 exec_err_i = 1'b0;
    idle(2);
    read_expect("R9 exec error code", '{8'h0F});

    // R5 length 0 ends immediately
    a0 = n_abort;
    send_byte(8'h66); send_byte(8'h00);
    idle(3);
    chk("R5 length 0 abort", n_abort - a0, 1);
    read_expect("R5 flag after length 0", '{8'hFF});

    // R2/R3 boundary lengths 4 and 39, empty close gives 0x00
    e0 = n_end;
    send_cmd('{8'h5A}, 1);
    chk("R3 length 4 accepted", n_end - e0, 1);
    push_rsp('{});
    read_expect("R9 empty close", '{8'h00});
    p = {};
    for (int k = 0; k < 36; k++) p.push_back(8'(k * 7 + 3));
    e0 = n_end;
    send_cmd(p, 1);
    chk("R3 length 39 accepted", n_end - e0, 1);
    chk("R2 length 39 bytes seen", exp_cmd.size(), 0);

    // R9 overflow beyond depth
    push_rsp('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A});
    read_expect("R9 overflow dropped", '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08});

    // R11 bytes during transmission ignored
    ready_mode = 1;
    s0 = n_sleep;
    txq.delete();
    send_byte(8'h99);
    idle(3);
    send_byte(8'hCC); send_byte(8'h66); send_byte(8'h04);
    idle(3);
    ready_mode = 2;
    idle(20);
    chk("R11 no sleep during tx", n_sleep - s0, 0);
    chk("R11 full block sent", txq.size(), 11);
    if (txq.size() > 0) chk("R11 count byte", txq[0], 11);

    // R8/R6 sleep while busy
    ready_mode = 0;
    send_cmd('{8'h08, 8'h01, 8'h00, 8'h00}, 1);
    s0 = n_sleep;
    send_byte(8'hCC);
    idle(3);
    chk("R8 sleep acts while busy", n_sleep - s0, 1);
    read_expect("R6 wake code after sleep", '{8'h11});

    chk("R2 no leftover packet bytes", exp_cmd.size(), 0);
    finish_run();
  end
endmodule